// File: doc/BRIEF.md
# Packed-Instruction 64-bit Math Engine

This block runs a stream of 32-bit ALU instruction words against a file of sixteen 64-bit general-purpose registers. An instruction does one of three things. It stages an operand into one of two source latches, called A and B. It combines the two latches into an accumulator and updates a zero flag and a carry flag. Or it writes the accumulator or one of the flags back into a register.

A comparison is done with a subtract followed by a store of the zero or carry flag, raw or inverted. The stored flag fills all 64 bits, so the result is either all ones or all zeros.

A host reaches the registers through a 32-bit read/write port. The register file sits in a byte-addressed window: each register takes 8 bytes and its upper half is at +4. Instruction words arrive on a valid/ready handshake, at most one per cycle. An illegal word raises a sticky error flag and is dropped without changing any state.

Top module: `cs_math_alu`

## Requirements
- R1: After reset every register reads zero, `aluErr` is 0 and `insReady` is 1 from the first clock edge after reset is released.
- R2: A host access to byte address `BASE_ADDR + 8*i` reaches bits [31:0] of register i, and one to `BASE_ADDR + 8*i + 4` reaches bits [63:32]. A write outside the 128-byte window, or to an address whose bits [1:0] are not zero, changes nothing. A read of such an address returns 0.
- R3: An instruction word carries the opcode in bits [31:20], operand 1 in [19:10] and operand 2 in [9:0]. The operand codes are latch A = 0x020, latch B = 0x021, accumulator = 0x031, zero flag = 0x032, carry flag = 0x033, and register i = i for i from 0 to 15. The opcodes are NOP 0x000, LOAD 0x080, LOADINV 0x480, LOAD0 0x081, LOAD1 0x481, ADD 0x100, SUB 0x101, AND 0x102, OR 0x103, SHL 0x105, SHR 0x106, SAR 0x107, STORE 0x180 and STOREINV 0x580.
- R4: LOAD and LOADINV copy register (operand 2), or its bitwise complement, into the latch named by operand 1. LOAD0 and LOAD1 put all zeros or all ones into the named latch without reading any register.
- R5: ADD and SUB put A+B or A−B (modulo 2^64) into the accumulator. The zero flag is set exactly when that result is zero. After ADD the carry flag holds the carry out of bit 63. After SUB it is set exactly when A < B as unsigned values.
- R6: AND and OR put A&B or A|B into the accumulator. The zero flag is set exactly when the result is zero, and the carry flag is cleared.
- R7: SHL, SHR and SAR shift A left, logically right or arithmetically right by B places, where B is one of 0, 1, 2, 4, 8, 16 or 32. The result goes into the accumulator, and both flags keep their values.
- R8: STORE writes the accumulator, zero flag or carry flag (operand 2) into register (operand 1), and STOREINV writes the complement. A flag is written as all ones when true and all zeros when false.
- R9: An undefined opcode raises `aluErr`. So do a load whose latch or register operand is invalid, a store whose target is not a register index or whose source is not accumulator, zero flag or carry flag, and a shift with any other B. `aluErr` stays set until reset, and such a word changes no register, latch, accumulator or flag.
- R10: While `insReady` is high, every cycle with `insValid` high retires one instruction. Each instruction sees the results of the one retired before it.
- R11: When a host write and an ALU store hit the same register in the same cycle, the whole register takes the stored value and the host write is dropped. A host write to a different register in that cycle still takes effect.
- R12: NOP changes no state and raises no error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| insValid | input | 1 | Instruction word present |
| insReady | output | 1 | Engine accepts a word this cycle |
| insWord | input | 32 | Packed instruction word |
| hostWe | input | 1 | Host write strobe |
| hostWAddr | input | HOST_AW (12) | Host write byte address |
| hostWData | input | 32 | Host write data (one half register) |
| hostRAddr | input | HOST_AW (12) | Host read byte address |
| hostRData | output | 32 | Host read data, combinational |
| aluErr | output | 1 | Sticky illegal-instruction flag |

## Verification
The bench goes after the unsigned borrow of SUB when the top bits differ. A design that took the borrow from a signed compare would store the wrong less-than word. It walks every legal shift amount and sets B to 3, 33 and 64. A design with a loose legality check would either shift by an odd amount or latch an error on a legal value. Each illegal word is followed by a full register readback, so a decoder that lets a half-executed load or store through shows up as a changed register. A host write and an ALU store are aimed at the same register in one cycle: if the priority is wrong, the host half survives in the readback.

// File: rtl/csalu_pkg.sv
`timescale 1ns/1ps
package csalu_pkg;
  localparam int NREG  = 16;
  localparam int IDXW  = $clog2(NREG);
  localparam int DW    = 64;
  localparam int OPCW  = 12;
  localparam int OPNW  = 10;

  localparam logic [OPCW-1:0] OPC_NOP      = 12'h000;
  localparam logic [OPCW-1:0] OPC_LOAD     = 12'h080;
  localparam logic [OPCW-1:0] OPC_LOADINV  = 12'h480;
  localparam logic [OPCW-1:0] OPC_LOAD0    = 12'h081;
  localparam logic [OPCW-1:0] OPC_LOAD1    = 12'h481;
  localparam logic [OPCW-1:0] OPC_ADD      = 12'h100;
  localparam logic [OPCW-1:0] OPC_SUB      = 12'h101;
  localparam logic [OPCW-1:0] OPC_AND      = 12'h102;
  localparam logic [OPCW-1:0] OPC_OR       = 12'h103;
  localparam logic [OPCW-1:0] OPC_SHL      = 12'h105;
  localparam logic [OPCW-1:0] OPC_SHR      = 12'h106;
  localparam logic [OPCW-1:0] OPC_SAR      = 12'h107;
  localparam logic [OPCW-1:0] OPC_STORE    = 12'h180;
  localparam logic [OPCW-1:0] OPC_STOREINV = 12'h580;

  localparam logic [OPNW-1:0] OPN_A    = 10'h020;
  localparam logic [OPNW-1:0] OPN_B    = 10'h021;
  localparam logic [OPNW-1:0] OPN_ACC  = 10'h031;
  localparam logic [OPNW-1:0] OPN_ZF   = 10'h032;
  localparam logic [OPNW-1:0] OPN_CF   = 10'h033;

  typedef enum logic [2:0] {
    ALU_ADD, ALU_SUB, ALU_AND, ALU_OR, ALU_SHL, ALU_SHR, ALU_SAR
  } aluOp_e;

  typedef enum logic [1:0] {LD_REG, LD_INV, LD_ZERO, LD_ONES} ldKind_e;

  typedef enum logic [1:0] {SRC_ACC, SRC_ZF, SRC_CF} stSrc_e;

  typedef struct packed {
    logic            ldA;
    logic            ldB;
    ldKind_e         ldKind;
    logic [IDXW-1:0] ldIdx;
    logic            aluEn;
    aluOp_e          aluOp;
    logic            stEn;
    logic [IDXW-1:0] stIdx;
    stSrc_e          stSrc;
    logic            stInv;
  } strobe_t;
endpackage

// File: rtl/csalu_ctrl.sv
`timescale 1ns/1ps
module csalu_ctrl
  import csalu_pkg::*;
(
  input  logic          clk,
  input  logic          rstN,
  input  logic          insValid,
  input  logic [31:0]   insWord,
  input  logic [DW-1:0] srcB,
  output logic          insReady,
  output strobe_t       strb,
  output logic          aluErr
);
  localparam int SHMAX = 32;

  logic [OPCW-1:0] opc;
  logic [OPNW-1:0] opn1, opn2;
  logic            fire, bad, shOk, latchOk;
  logic            readyQ, errQ;
  strobe_t         dec;

  assign opc  = insWord[31:20];
  assign opn1 = insWord[19:10];
  assign opn2 = insWord[9:0];
  assign fire = insValid && readyQ;

  // zero or a single set bit, no larger than SHMAX
  assign shOk    = ((srcB & (srcB - 1'b1)) == '0) && (srcB <= DW'(SHMAX));
  assign latchOk = (opn1 == OPN_A) || (opn1 == OPN_B);

  always_comb begin
    dec = '0;
    bad = 1'b0;
    unique case (opc)
      OPC_NOP: ;
      OPC_LOAD, OPC_LOADINV: begin
        if (latchOk && opn2 < OPNW'(NREG)) begin
          dec.ldA    = (opn1 == OPN_A);
          dec.ldB    = (opn1 == OPN_B);
          dec.ldKind = (opc == OPC_LOAD) ? LD_REG : LD_INV;
          dec.ldIdx  = opn2[IDXW-1:0];
        end else bad = 1'b1;
      end
      OPC_LOAD0, OPC_LOAD1: begin
        if (latchOk) begin
          dec.ldA    = (opn1 == OPN_A);
          dec.ldB    = (opn1 == OPN_B);
          dec.ldKind = (opc == OPC_LOAD0) ? LD_ZERO : LD_ONES;
        end else bad = 1'b1;
      end
      OPC_ADD: begin dec.aluEn = 1'b1; dec.aluOp = ALU_ADD; end
      OPC_SUB: begin dec.aluEn = 1'b1; dec.aluOp = ALU_SUB; end
      OPC_AND: begin dec.aluEn = 1'b1; dec.aluOp = ALU_AND; end
      OPC_OR:  begin dec.aluEn = 1'b1; dec.aluOp = ALU_OR;  end
      OPC_SHL, OPC_SHR, OPC_SAR: begin
        if (shOk) begin
          dec.aluEn = 1'b1;
          dec.aluOp = (opc == OPC_SHL) ? ALU_SHL :
                      (opc == OPC_SHR) ? ALU_SHR : ALU_SAR;
        end else bad = 1'b1;
      end
      OPC_STORE, OPC_STOREINV: begin
        if (opn1 < OPNW'(NREG) &&
            (opn2 == OPN_ACC || opn2 == OPN_ZF || opn2 == OPN_CF)) begin
          dec.stEn  = 1'b1;
          dec.stIdx = opn1[IDXW-1:0];
          dec.stSrc = (opn2 == OPN_ACC) ? SRC_ACC :
                      (opn2 == OPN_ZF)  ? SRC_ZF  : SRC_CF;
          dec.stInv = (opc == OPC_STOREINV);
        end else bad = 1'b1;
      end
      default: bad = 1'b1;
    endcase
  end

  assign strb = (fire && !bad) ? dec : '0;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      readyQ <= 1'b0;
      errQ   <= 1'b0;
    end else begin
      readyQ <= 1'b1;
      if (fire && bad) errQ <= 1'b1;
    end
  end

  assign insReady = readyQ;
  assign aluErr   = errQ;

  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    aluErr |=> aluErr); // R9
  AST_ONE_ACTION: assert property (@(posedge clk) disable iff (!rstN)
    $countones({strb.ldA, strb.ldB, strb.aluEn, strb.stEn}) <= 1); // R10
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    !insValid |-> !(strb.ldA || strb.ldB || strb.aluEn || strb.stEn)); // R10
endmodule

// File: rtl/csalu_dp.sv
`timescale 1ns/1ps
module csalu_dp
  import csalu_pkg::*;
#(
  parameter int               HOST_AW   = 12,
  parameter logic [HOST_AW-1:0] BASE_ADDR = 12'h600
)(
  input  logic               clk,
  input  logic               rstN,
  input  strobe_t            strb,
  input  logic               hostWe,
  input  logic [HOST_AW-1:0] hostWAddr,
  input  logic [31:0]        hostWData,
  input  logic [HOST_AW-1:0] hostRAddr,
  output logic [31:0]        hostRData,
  output logic [DW-1:0]      srcB
);
  localparam logic [HOST_AW-1:0] WIN_BYTES = HOST_AW'(NREG * 8);

  logic [DW-1:0] regVec [NREG];
  logic [DW-1:0] srcA, accQ, ldVal, aluRes, stVal, flagWord;
  logic          zfQ, cfQ, aluCarry;
  logic [5:0]    shAmt;

  // host window decode
  logic [HOST_AW-1:0] wOff, rOff;
  logic               wHit, rHit, wHi, rHi;
  logic [IDXW-1:0]    wIdx, rIdx;

  assign wOff = hostWAddr - BASE_ADDR;
  assign rOff = hostRAddr - BASE_ADDR;
  assign wHit = hostWe && (hostWAddr >= BASE_ADDR) && (wOff < WIN_BYTES) && (wOff[1:0] == 2'b00);
  assign rHit = (hostRAddr >= BASE_ADDR) && (rOff < WIN_BYTES) && (rOff[1:0] == 2'b00);
  assign wIdx = wOff[IDXW+2:3];
  assign rIdx = rOff[IDXW+2:3];
  assign wHi  = wOff[2];
  assign rHi  = rOff[2];

  assign hostRData = !rHit ? 32'h0 : (rHi ? regVec[rIdx][63:32] : regVec[rIdx][31:0]);

  // operand staging
  always_comb begin
    unique case (strb.ldKind)
      LD_REG:  ldVal = regVec[strb.ldIdx];
      LD_INV:  ldVal = ~regVec[strb.ldIdx];
      LD_ZERO: ldVal = '0;
      default: ldVal = '1;
    endcase
  end

  // arithmetic / logic / shift
  assign shAmt = srcB[5:0];
  always_comb begin
    aluCarry = 1'b0;
    unique case (strb.aluOp)
      ALU_ADD: {aluCarry, aluRes} = {1'b0, srcA} + {1'b0, srcB};
      ALU_SUB: {aluCarry, aluRes} = {1'b0, srcA} - {1'b0, srcB};
      ALU_AND: aluRes = srcA & srcB;
      ALU_OR:  aluRes = srcA | srcB;
      ALU_SHL: aluRes = srcA << shAmt;
      ALU_SHR: aluRes = srcA >> shAmt;
      default: aluRes = DW'($signed(srcA) >>> shAmt);
    endcase
  end

  logic isShift;
  assign isShift = (strb.aluOp == ALU_SHL) || (strb.aluOp == ALU_SHR) || (strb.aluOp == ALU_SAR);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      srcA <= '0;
      srcB <= '0;
      accQ <= '0;
      zfQ  <= 1'b0;
      cfQ  <= 1'b0;
    end else begin
      if (strb.ldA) srcA <= ldVal;
      if (strb.ldB) srcB <= ldVal;
      if (strb.aluEn) begin
        accQ <= aluRes;
        if (!isShift) begin
          zfQ <= (aluRes == '0);
          cfQ <= aluCarry;
        end
      end
    end
  end

  // write-back value
  always_comb begin
    unique case (strb.stSrc)
      SRC_ZF:  flagWord = {DW{zfQ}};
      SRC_CF:  flagWord = {DW{cfQ}};
      default: flagWord = accQ;
    endcase
    stVal = strb.stInv ? ~flagWord : flagWord;
  end

  // register file: ALU store has priority over the host port
  for (genvar g = 0; g < NREG; g++) begin : gReg
    logic [DW-1:0] q;
    always_ff @(posedge clk) begin
      if (!rstN) q <= '0;
      else if (strb.stEn && strb.stIdx == IDXW'(g)) q <= stVal;
      else if (wHit && wIdx == IDXW'(g)) begin
        if (wHi) q[63:32] <= hostWData;
        else     q[31:0]  <= hostWData;
      end
    end
    assign regVec[g] = q;
  end

  AST_SUB_BORROW: assert property (@(posedge clk) disable iff (!rstN)
    strb.aluEn && strb.aluOp == ALU_SUB |=> cfQ == ($past(srcA) < $past(srcB))); // R5
  AST_LOGIC_CF_CLR: assert property (@(posedge clk) disable iff (!rstN)
    strb.aluEn && (strb.aluOp == ALU_AND || strb.aluOp == ALU_OR) |=> !cfQ); // R6
  AST_SHIFT_FLAGS: assert property (@(posedge clk) disable iff (!rstN)
    strb.aluEn && isShift |=> $stable(zfQ) && $stable(cfQ)); // R7
  AST_FLAG_WORD: assert property (@(posedge clk) disable iff (!rstN)
    strb.stEn && strb.stSrc != SRC_ACC |=>
      (regVec[$past(strb.stIdx)] == '0 || regVec[$past(strb.stIdx)] == '1)); // R8
  AST_ALU_WINS: assert property (@(posedge clk) disable iff (!rstN)
    strb.stEn && wHit && wIdx == strb.stIdx |=> regVec[$past(strb.stIdx)] == $past(stVal)); // R11
endmodule

// File: rtl/cs_math_alu.sv
`timescale 1ns/1ps
module cs_math_alu
  import csalu_pkg::*;
#(
  parameter int                 HOST_AW   = 12,
  parameter logic [HOST_AW-1:0] BASE_ADDR = 12'h600
)(
  input  logic               clk,
  input  logic               rstN,
  input  logic               insValid,
  output logic               insReady,
  input  logic [31:0]        insWord,
  input  logic               hostWe,
  input  logic [HOST_AW-1:0] hostWAddr,
  input  logic [31:0]        hostWData,
  input  logic [HOST_AW-1:0] hostRAddr,
  output logic [31:0]        hostRData,
  output logic               aluErr
);
  strobe_t       strb;
  logic [DW-1:0] srcB;

  csalu_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .insValid (insValid),
    .insWord  (insWord),
    .srcB     (srcB),
    .insReady (insReady),
    .strb     (strb),
    .aluErr   (aluErr)
  );

  csalu_dp #(.HOST_AW(HOST_AW), .BASE_ADDR(BASE_ADDR)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strb      (strb),
    .hostWe    (hostWe),
    .hostWAddr (hostWAddr),
    .hostWData (hostWData),
    .hostRAddr (hostRAddr),
    .hostRData (hostRData),
    .srcB      (srcB)
  );

  AST_READY_AFTER_RST: assert property (@(posedge clk) disable iff (!rstN)
    $past(rstN) |-> insReady); // R1
endmodule

// File: tb/sim_cs_math_alu.sv
`timescale 1ns/1ps
module sim_cs_math_alu;
  localparam logic [11:0] BASE = 12'h600;
  localparam logic [11:0] NOP = 12'h000, LD = 12'h080, LDI = 12'h480, LD0 = 12'h081, LD1 = 12'h481;
  localparam logic [11:0] ADD = 12'h100, SUB = 12'h101, AND_ = 12'h102, OR_ = 12'h103;
  localparam logic [11:0] SHL = 12'h105, SHR = 12'h106, SAR = 12'h107, ST = 12'h180, STI = 12'h580;
  localparam logic [9:0]  LA = 10'h020, LB = 10'h021, SACC = 10'h031, SZF = 10'h032, SCF = 10'h033;

  logic clk = 1'b0, rstN = 1'b0;
  logic insValid = 1'b0, insReady;
  logic [31:0] insWord = '0;
  logic hostWe = 1'b0;
  logic [11:0] hostWAddr = '0, hostRAddr = '0;
  logic [31:0] hostWData = '0, hostRData;
  logic aluErr;

  int nTests = 0, nFail = 0;

  always #4 clk = ~clk;

  cs_math_alu u0 (.clk(clk), .rstN(rstN), .insValid(insValid), .insReady(insReady), .insWord(insWord),
    .hostWe(hostWe), .hostWAddr(hostWAddr), .hostWData(hostWData), .hostRAddr(hostRAddr),
    .hostRData(hostRData), .aluErr(aluErr));

  // reference state
  logic [63:0] mR [16];
  logic [63:0] mA, mB, mAcc;
  logic mZf, mCf, mErr;

  function automatic logic [31:0] mk(input logic [11:0] o, input logic [9:0] p, input logic [9:0] q);
    return {o, p, q};
  endfunction

  function automatic bit legalShift(input logic [63:0] v);
    case (v)
      64'd0, 64'd1, 64'd2, 64'd4, 64'd8, 64'd16, 64'd32: return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

  task automatic mdl(input logic [31:0] w, output bit stored, output int sIdx);
    logic [11:0] o; logic [9:0] p, q; logic [63:0] v; logic [64:0] wide;
    o = w[31:20]; p = w[19:10]; q = w[9:0];
    stored = 1'b0; sIdx = -1;
    case (o)
      NOP: ;
      LD, LDI: if ((p == LA || p == LB) && q < 16) begin
          v = (o == LD) ? mR[q] : ~mR[q];
          if (p == LA) mA = v; else mB = v;
        end else mErr = 1'b1;
      LD0, LD1: if (p == LA || p == LB) begin
          v = (o == LD0) ? 64'd0 : ~64'd0;
          if (p == LA) mA = v; else mB = v;
        end else mErr = 1'b1;
      ADD: begin wide = {1'b0, mA} + {1'b0, mB}; mAcc = wide[63:0]; mCf = wide[64]; mZf = (mAcc == 0); end
      SUB: begin mAcc = mA - mB; mCf = (mA < mB); mZf = (mA == mB); end
      AND_: begin mAcc = mA & mB; mCf = 1'b0; mZf = (mAcc == 0); end
      OR_:  begin mAcc = mA | mB; mCf = 1'b0; mZf = (mAcc == 0); end
      SHL, SHR, SAR: if (legalShift(mB)) begin
          if (o == SHL) mAcc = mA << mB[5:0];
          else if (o == SHR) mAcc = mA >> mB[5:0];
          else mAcc = $signed(mA) >>> mB[5:0];
        end else mErr = 1'b1;
      ST, STI: if (p < 16 && (q == SACC || q == SZF || q == SCF)) begin
          v = (q == SACC) ? mAcc : (q == SZF) ? {64{mZf}} : {64{mCf}};
          mR[p] = (o == STI) ? ~v : v;
          stored = 1'b1; sIdx = int'(p);
        end else mErr = 1'b1;
      default: mErr = 1'b1;
    endcase
  endtask

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    nTests++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // one instruction, optionally with a host write in the same cycle
  task automatic issue(input logic [31:0] w, input bit doHost = 0,
                       input logic [11:0] ha = '0, input logic [31:0] hd = '0);
    bit st; int si; logic [11:0] off;
    @(negedge clk);
    insValid = 1'b1; insWord = w;
    hostWe = doHost; hostWAddr = ha; hostWData = hd;
    @(posedge clk);
    #1;
    mdl(w, st, si);
    off = ha - BASE;
    if (doHost && ha >= BASE && off < 12'h080 && off[1:0] == 2'b00 && !(st && si == int'(off[6:3]))) begin
      if (off[2]) mR[off[6:3]][63:32] = hd; else mR[off[6:3]][31:0] = hd;
    end
    insValid = 1'b0; hostWe = 1'b0;
  endtask

  task automatic hostWrite(input logic [11:0] ha, input logic [31:0] hd);
    logic [11:0] off;
    @(negedge clk);
    hostWe = 1'b1; hostWAddr = ha; hostWData = hd;
    @(posedge clk);
    #1;
    hostWe = 1'b0;
    off = ha - BASE;
    if (ha >= BASE && off < 12'h080 && off[1:0] == 2'b00) begin
      if (off[2]) mR[off[6:3]][63:32] = hd; else mR[off[6:3]][31:0] = hd;
    end
  endtask

  task automatic readReg(input int i, output logic [63:0] v);
    @(negedge clk);
    hostRAddr = BASE + 12'(8 * i);     #1; v[31:0]  = hostRData;
    hostRAddr = BASE + 12'(8 * i + 4); #1; v[63:32] = hostRData;
  endtask

  task automatic checkAll(input string req);
    logic [63:0] v;
    for (int i = 0; i < 16; i++) begin
      readReg(i, v);
      check(req, v, mR[i]);
    end
    check({req, " err"}, {63'd0, aluErr}, {63'd0, mErr});
  endtask

  function automatic logic [31:0] randIns();
    int k;
    k = $urandom % 16;
    case (k)
      0, 1, 2: return mk(LD, ($urandom % 2) ? LB : LA, 10'($urandom % 16));
      3:  return mk(LDI, ($urandom % 2) ? LB : LA, 10'($urandom % 16));
      4:  return mk(($urandom % 2) ? LD1 : LD0, ($urandom % 2) ? LB : LA, 10'd0);
      5:  return mk(ADD, 10'd0, 10'd0);
      6:  return mk(SUB, 10'd0, 10'd0);
      7:  return mk(($urandom % 2) ? AND_ : OR_, 10'd0, 10'd0);
      8, 15: begin
        case ($urandom % 3)
          0: return mk(SHL, 10'd0, 10'd0);
          1: return mk(SHR, 10'd0, 10'd0);
          default: return mk(SAR, 10'd0, 10'd0);
        endcase
      end
      9:  return mk(LD, LB, 10'(12 + $urandom % 4));
      10, 11, 12: begin
        logic [9:0] s;
        s = (($urandom % 3) == 0) ? SACC : (($urandom % 2) != 0) ? SZF : SCF;
        return mk(($urandom % 2) ? STI : ST, 10'($urandom % 12), s);
      end
      13: return mk(NOP, 10'd0, 10'd0);
      default: return (($urandom % 4) == 0) ? mk(12'h7FF, 10'd0, 10'd0) : mk(LD, LA, 10'($urandom % 16));
    endcase
  endfunction

  task automatic finishRun();
    $display("[TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  endtask

  initial begin
    #1_600_000;
    nFail++;
    $display("FAIL R10 watchdog expired actual=running expected=done");
    finishRun();
  end

  initial begin
    logic [63:0] v;
    void'($urandom(32'd20240607));
    for (int i = 0; i < 16; i++) mR[i] = '0;
    mA = '0; mB = '0; mAcc = '0; mZf = 1'b0; mCf = 1'b0; mErr = 1'b0;
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;
    @(posedge clk); #1;
    // R1 reset state
    check("R1 ready", {63'd0, insReady}, 64'd1);
    checkAll("R1");

    // R2 host window mapping
    for (int i = 0; i < 16; i++) begin
      hostWrite(BASE + 12'(8 * i), $urandom);
      hostWrite(BASE + 12'(8 * i + 4), $urandom);
    end
    hostWrite(12'h5FC, 32'hDEAD_BEEF);
    hostWrite(12'h680, 32'hDEAD_BEEF);
    hostWrite(12'h601, 32'hDEAD_BEEF);
    checkAll("R2");
    @(negedge clk); hostRAddr = 12'h680; #1;
    check("R2 outside read", {32'd0, hostRData}, 64'd0);

    // R5 / R8 compare via SUB, unsigned borrow with top bit set
    hostWrite(BASE + 12'h00, 32'h0000_0001); hostWrite(BASE + 12'h04, 32'h8000_0000);
    hostWrite(BASE + 12'h08, 32'h0000_0002); hostWrite(BASE + 12'h0C, 32'h0000_0000);
    issue(mk(LD, LA, 10'd1)); issue(mk(LD, LB, 10'd0)); issue(mk(SUB, 10'd0, 10'd0));
    issue(mk(ST, 10'd2, SCF)); issue(mk(STI, 10'd3, SZF));
    readReg(2, v); check("R5 R8 unsigned less-than word", v, 64'hFFFF_FFFF_FFFF_FFFF);
    readReg(3, v); check("R8 inverted zero flag", v, 64'hFFFF_FFFF_FFFF_FFFF);
    issue(mk(LD, LB, 10'd1)); issue(mk(SUB, 10'd0, 10'd0)); issue(mk(ST, 10'd4, SZF));
    readReg(4, v); check("R5 equal sets zero", v, 64'hFFFF_FFFF_FFFF_FFFF);
    // R5 ADD carry out
    issue(mk(LD1, LA, 10'd0)); issue(mk(LD1, LB, 10'd0)); issue(mk(ADD, 10'd0, 10'd0));
    issue(mk(ST, 10'd5, SCF)); issue(mk(ST, 10'd6, SACC));
    readReg(5, v); check("R5 add carry", v, 64'hFFFF_FFFF_FFFF_FFFF);
    readReg(6, v); check("R5 add sum", v, 64'hFFFF_FFFF_FFFF_FFFE);
    // R4 / R6 inverted load and logic ops
    issue(mk(LDI, LA, 10'd6)); issue(mk(LD0, LB, 10'd0)); issue(mk(OR_, 10'd0, 10'd0));
    issue(mk(ST, 10'd7, SACC)); issue(mk(ST, 10'd8, SCF));
    readReg(7, v); check("R4 R6 inverted load or", v, 64'd1);
    readReg(8, v); check("R6 carry cleared", v, 64'd0);
    checkAll("R4 R6");

    // R7 every legal shift amount
    hostWrite(BASE + 12'h48, 32'h1234_5678); hostWrite(BASE + 12'h4C, 32'h9ABC_DEF0);
    foreach (mR[i]) ;
    for (int s = 0; s < 7; s++) begin
      logic [31:0] amt;
      amt = (s == 0) ? 32'd0 : (32'd1 << (s - 1));
      hostWrite(BASE + 12'h50, amt); hostWrite(BASE + 12'h54, 32'd0);
      issue(mk(LD, LA, 10'd9)); issue(mk(LD, LB, 10'd10));
      issue(mk(SHL, 10'd0, 10'd0)); issue(mk(ST, 10'd11, SACC));
      issue(mk(SAR, 10'd0, 10'd0)); issue(mk(ST, 10'd12, SACC));
      issue(mk(SHR, 10'd0, 10'd0)); issue(mk(ST, 10'd13, SACC));
    end
    checkAll("R7");
    check("R7 legal shifts leave no error", {63'd0, aluErr}, 64'd0);

    // R12 NOP
    issue(mk(NOP, 10'd0, 10'd0));
    checkAll("R12");

    // R9 illegal words: no state change, sticky error
    hostWrite(BASE + 12'h50, 32'd3);
    issue(mk(LD, LB, 10'd10)); issue(mk(SHL, 10'd0, 10'd0)); issue(mk(ST, 10'd14, SACC));
    checkAll("R9 shift by 3");
    check("R9 error raised", {63'd0, aluErr}, 64'd1);
    hostWrite(BASE + 12'h50, 32'd33); issue(mk(LD, LB, 10'd10)); issue(mk(SHR, 10'd0, 10'd0));
    hostWrite(BASE + 12'h50, 32'd64); issue(mk(LD, LB, 10'd10)); issue(mk(SAR, 10'd0, 10'd0));
    issue(mk(ST, 10'd14, SACC));
    issue(mk(12'h7FF, 10'd0, 10'd0));
    issue(mk(ST, LA, SACC));
    issue(mk(ST, 10'd3, 10'd5));
    issue(mk(LD, 10'd7, 10'd1));
    issue(mk(LD, LA, 10'd16));
    issue(mk(ST, 10'd15, SACC));
    checkAll("R9");

    // R11 store vs host write same register, and a different one
    issue(mk(ST, 10'd5, SACC), 1'b1, BASE + 12'h28, 32'hCAFE_F00D);
    issue(mk(ST, 10'd6, SZF), 1'b1, BASE + 12'h3C, 32'h0BAD_CAFE);
    checkAll("R11");

    // R10 back-to-back random stream
    for (int n = 0; n < 2000; n++) begin
      issue(randIns());
      if (n % 250 == 249) checkAll("R10 R3 random");
    end
    checkAll("R10 R3 random final");
    finishRun();
  end
endmodule